// File: doc/BRIEF.md
# Quadrature Position Decoder with Index Supervision

This block turns the two phase signals of an incremental shaft encoder into a position count. The phases are 90 degrees apart, and an optional once-per-turn index pulse can accompany them. Every edge on either phase moves the count by one (4x decoding). The counter runs on the undivided system clock and wraps at a programmable top value. When the top value is set to four times the encoder's line count minus one, the count equals the shaft angle and can be read at any moment with no conversion.

Phase A, phase B and the index are asynchronous to the clock, so each is retimed before use. The phase pair is decoded as a Gray code. Index supervision compares the index with the count. It raises a sticky error when the index arrives away from zero, or when the count wraps through zero without the index. Supervision can be turned off for encoders that have no index. The block has no streaming data path, so every pin is a plain level-sensitive control or status signal, sampled or updated on each rising clock edge.

Top module: `qdec_index_top`

## Requirements
- R1: While `rst` is high at a clock edge, the outputs take these values at that edge: `count` is 0, `dir_up` is 1 and `err` is 0.
- R2: `pha`, `phb` and `idx` each pass through a two-flop synchroniser. A phase change driven before clock edge 1 appears on `count` after clock edge 3 and not earlier.
- R3: The phase pair {pha,phb} moving one step along 00→01→11→10→00 increments `count` by one for each step.
- R4: Steps in the reverse order (00→10→11→01→00) decrement `count` by one for each step.
- R5: When both phases change in the same synchronised sample (for example 11→00), the change is ignored: `count` and `dir_up` keep their values. The new phase state becomes the reference for the next legal step.
- R6: An up step from a count equal to or above `period` gives 0. A down step from 0 gives `period`.
- R7: While `en` is low, `count` and `dir_up` hold. Phase movement seen while disabled is tracked but never counted later.
- R8: With `en` and `idx_en` high, the cycle in which the synchronised index is first seen high sets `err` if the count resulting from that cycle is not 0.
- R9: With `en` and `idx_en` high, a wrap step (up to 0 or down to `period`) sets `err` if the synchronised index is low in that cycle.
- R10: An index that rises together with the step wrapping to 0, or while the count rests at 0, leaves `err` low.
- R11: With `idx_en` low, `err` is never set.
- R12: `err` stays set until a one-cycle `err_clr`. If a clear and a new error fall in the same cycle, `err` ends up set.
- R13: `dir_up` is 1 after the most recent valid up step and 0 after the most recent valid down step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, undivided count clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Counting enable |
| idx_en | input | 1 | Index supervision enable |
| pha | input | 1 | Encoder phase A (asynchronous) |
| phb | input | 1 | Encoder phase B, 90 degrees from A (asynchronous) |
| idx | input | 1 | Encoder index pulse (asynchronous, optional) |
| period | input | CNT_W | Top value of the count (line count * 4 - 1) |
| err_clr | input | 1 | One-cycle clear of the error flag |
| count | output | CNT_W | Position count, equal to shaft angle |
| dir_up | output | 1 | Sign of the most recent valid step, 1 = up |
| err | output | 1 | Sticky index/count mismatch flag |

## Verification
The index detector and the counter's wrap can act in the same clock cycle. The bench causes this by driving the index high together with the phase step that carries the count from `period` to 0. Both then pass through equal-length synchronisers and meet at the same edge. The check passes only if the count reads 0 and `err` stays low, and it would fail if the index were compared with the count before the step. A second collision, a clear landing in the same cycle as a fresh index error, is timed by asserting `err_clr` one cycle after the index reaches the second synchroniser stage. The check passes if `err` reads high afterwards.

// File: rtl/qdec_pkg.sv
package qdec_pkg;

  typedef enum logic [1:0] {
    STEP_NONE = 2'd0,
    STEP_UP   = 2'd1,
    STEP_DOWN = 2'd2,
    STEP_BAD  = 2'd3
  } step_e;

  // Position of a phase pair on the up cycle 00,01,11,10 -> 0,1,2,3
  function automatic logic [1:0] gray_pos(input logic [1:0] ab);
    return {ab[1], ab[1] ^ ab[0]};
  endfunction

endpackage

// File: rtl/qdec_sync.sv
module qdec_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/qdec_step.sv
module qdec_step
  import qdec_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] ab,
  output step_e      step
);
  logic [1:0] ab_q;
  logic [1:0] delta;

  // Reference state is tracked every cycle, counting enabled or not
  always_ff @(posedge clk) begin
    if (rst) ab_q <= 2'b00;
    else     ab_q <= ab;
  end

  assign delta = gray_pos(ab) - gray_pos(ab_q);

  always_comb begin
    case (delta)
      2'd1:    step = STEP_UP;
      2'd3:    step = STEP_DOWN;
      2'd2:    step = STEP_BAD;
      default: step = STEP_NONE;
    endcase
  end
endmodule

// File: rtl/qdec_counter.sv
module qdec_counter
  import qdec_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         en,
  input  step_e        step,
  input  logic [W-1:0] period,
  output logic [W-1:0] count,
  output logic [W-1:0] cnt_nxt,
  output logic         wrap,
  output logic         dir_up
);
  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    cnt_nxt = count;
    wrap    = 1'b0;
    if (en) begin
      case (step)
        STEP_UP: begin
          if (count >= period) begin
            cnt_nxt = '0;
            wrap    = 1'b1;
          end else begin
            cnt_nxt = count + ONE;
          end
        end
        STEP_DOWN: begin
          if (count == '0) begin
            cnt_nxt = period;
            wrap    = 1'b1;
          end else begin
            cnt_nxt = count - ONE;
          end
        end
        default: cnt_nxt = count;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      dir_up <= 1'b1;
    end else begin
      count <= cnt_nxt;
      if (en && step == STEP_UP)   dir_up <= 1'b1;
      if (en && step == STEP_DOWN) dir_up <= 1'b0;
    end
  end
endmodule

// File: rtl/qdec_index_chk.sv
module qdec_index_chk #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         chk_en,
  input  logic         idx,
  input  logic [W-1:0] cnt_nxt,
  input  logic         wrap,
  input  logic         clr,
  output logic         err
);
  logic idx_q;
  logic idx_rise;
  logic set_err;

  always_ff @(posedge clk) begin
    if (rst) idx_q <= 1'b0;
    else     idx_q <= idx;
  end

  assign idx_rise = idx & ~idx_q;
  // Index is judged against the count this cycle produces
  assign set_err  = chk_en & ((idx_rise & (cnt_nxt != '0)) | (wrap & ~idx));

  always_ff @(posedge clk) begin
    if (rst) err <= 1'b0;
    else     err <= (err & ~clr) | set_err;
  end
endmodule

// File: rtl/qdec_index_top.sv
module qdec_index_top
  import qdec_pkg::*;
#(
  parameter int CNT_W       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             idx_en,
  input  logic             pha,
  input  logic             phb,
  input  logic             idx,
  input  logic [CNT_W-1:0] period,
  input  logic             err_clr,
  output logic [CNT_W-1:0] count,
  output logic             dir_up,
  output logic             err
);
  localparam int NSIG = 3;

  logic [NSIG-1:0]  raw_in;
  logic [NSIG-1:0]  syn;
  step_e            step;
  logic [CNT_W-1:0] cnt_nxt;
  logic             wrap;

  assign raw_in = {idx, pha, phb};

  qdec_sync #(.WIDTH(NSIG), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .d(raw_in), .q(syn)
  );

  qdec_step u_step (
    .clk(clk), .rst(rst), .ab(syn[1:0]), .step(step)
  );

  qdec_counter #(.W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en), .step(step), .period(period),
    .count(count), .cnt_nxt(cnt_nxt), .wrap(wrap), .dir_up(dir_up)
  );

  qdec_index_chk #(.W(CNT_W)) u_chk (
    .clk(clk), .rst(rst), .chk_en(en & idx_en), .idx(syn[2]),
    .cnt_nxt(cnt_nxt), .wrap(wrap), .clr(err_clr), .err(err)
  );
endmodule

// File: rtl/qdec_checker.sv
module qdec_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         en,
  input logic         idx_en,
  input logic [W-1:0] period,
  input logic         err_clr,
  input logic [W-1:0] count,
  input logic         dir_up,
  input logic         err
);
  localparam logic [W-1:0] ONE = W'(1);

  a_r12_err_sticky: assert property (@(posedge clk) disable iff (rst)
    err && !err_clr |=> err);

  a_r12_clear_works: assert property (@(posedge clk) disable iff (rst)
    err && err_clr && !(en && idx_en) |=> !err);

  a_r11_no_err_unsupervised: assert property (@(posedge clk) disable iff (rst)
    !err && !(en && idx_en) |=> !err);

  a_r7_count_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(count));

  a_r13_dir_hold: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dir_up));

  a_r6_in_range: assert property (@(posedge clk) disable iff (rst)
    $stable(period) && count <= period |=> count <= period);

  a_r3_single_move: assert property (@(posedge clk) disable iff (rst)
    count != $past(count) |-> (count == $past(count) + ONE) ||
                             (count + ONE == $past(count)) ||
                             (count == '0) || (count == $past(period)));
endmodule

bind qdec_index_top qdec_checker #(.W(CNT_W)) u_qdec_checker (
  .clk(clk), .rst(rst), .en(en), .idx_en(idx_en), .period(period),
  .err_clr(err_clr), .count(count), .dir_up(dir_up), .err(err)
);

// File: tb/qdec_index_top_test.sv
`timescale 1ns/1ps
module qdec_index_top_test;
  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         en = 1'b1;
  logic         idx_en = 1'b0;
  logic         pha = 1'b0;
  logic         phb = 1'b0;
  logic         idx = 1'b0;
  logic [W-1:0] period = 16'd11;
  logic         err_clr = 1'b0;
  logic [W-1:0] count;
  logic         dir_up;
  logic         err;

  int checks = 0;
  int errors = 0;
  logic [1:0] pos = 2'd0;

  always #2.5 clk = ~clk;

  qdec_index_top #(.CNT_W(W)) uut (
    .clk(clk), .rst(rst), .en(en), .idx_en(idx_en), .pha(pha), .phb(phb),
    .idx(idx), .period(period), .err_clr(err_clr), .count(count),
    .dir_up(dir_up), .err(err)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [1:0] ab_of(input logic [1:0] p);
    case (p)
      2'd0: return 2'b00;
      2'd1: return 2'b01;
      2'd2: return 2'b11;
      default: return 2'b10;
    endcase
  endfunction

  // Drive one quadrature step (no wait)
  task automatic set_step(input bit up);
    pos = up ? pos + 2'd1 : pos - 2'd1;
    {pha, phb} = ab_of(pos);
  endtask

  task automatic mv(input bit up);
    set_step(up);
    tick(4);
  endtask

  task automatic idx_pulse();
    idx = 1'b1; tick(4);
    idx = 1'b0; tick(4);
  endtask

  task automatic t_reset();
    chk("R1", "count", 32'(count), 0);
    chk("R1", "dir_up", 32'(dir_up), 1);
    chk("R1", "err", 32'(err), 0);
  endtask

  task automatic t_latency();
    set_step(1'b1);
    tick(2);
    chk("R2", "count after 2 edges", 32'(count), 0);
    tick(1);
    chk("R2", "count after 3 edges", 32'(count), 1);
    tick(1);
  endtask

  task automatic t_up();
    for (int i = 0; i < 3; i++) mv(1'b1);
    chk("R3", "count after up steps", 32'(count), 4);
    chk("R13", "dir after up", 32'(dir_up), 1);
  endtask

  task automatic t_down();
    mv(1'b0); mv(1'b0);
    chk("R4", "count after down steps", 32'(count), 2);
    chk("R13", "dir after down", 32'(dir_up), 0);
  endtask

  task automatic t_illegal();
    pos = pos + 2'd2;
    {pha, phb} = ab_of(pos);
    tick(4);
    chk("R5", "count after double jump", 32'(count), 2);
    chk("R5", "dir after double jump", 32'(dir_up), 0);
    mv(1'b1);
    chk("R5", "count after next legal step", 32'(count), 3);
    chk("R13", "dir after next legal step", 32'(dir_up), 1);
  endtask

  task automatic t_wrap();
    for (int i = 0; i < 8; i++) mv(1'b1);
    chk("R6", "count at top", 32'(count), 11);
    mv(1'b1);
    chk("R6", "up wrap to zero", 32'(count), 0);
    mv(1'b0);
    chk("R6", "down wrap to period", 32'(count), 11);
    mv(1'b1);
    chk("R11", "no err on wrap unsupervised", 32'(err), 0);
  endtask

  task automatic t_enable();
    en = 1'b0;
    mv(1'b1); mv(1'b1);
    chk("R7", "count held while disabled", 32'(count), 0);
    en = 1'b1;
    tick(4);
    chk("R7", "no catch-up after enable", 32'(count), 0);
    mv(1'b1);
    chk("R7", "counting resumes", 32'(count), 1);
  endtask

  task automatic t_idx_off();
    idx_pulse();
    chk("R11", "index off at count 1", 32'(err), 0);
  endtask

  task automatic t_idx_good();
    mv(1'b0); mv(1'b0);
    chk("R6", "count before good index", 32'(count), 11);
    idx_en = 1'b1;
    set_step(1'b1);
    idx = 1'b1;
    tick(4);
    chk("R10", "count at index wrap", 32'(count), 0);
    chk("R10", "no err index with wrap", 32'(err), 0);
    idx = 1'b0; tick(4);
    idx_pulse();
    chk("R10", "no err index at zero", 32'(err), 0);
  endtask

  task automatic t_wrap_noidx();
    mv(1'b0);
    chk("R9", "err on wrap without index", 32'(err), 1);
    tick(6);
    chk("R12", "err sticky", 32'(err), 1);
  endtask

  task automatic t_clear();
    err_clr = 1'b1; tick(1);
    err_clr = 1'b0;
    chk("R12", "err cleared", 32'(err), 0);
  endtask

  task automatic t_idx_bad();
    idx_pulse();
    chk("R8", "err on index away from zero", 32'(err), 1);
    chk("R8", "count unchanged by index", 32'(count), 11);
    t_clear();
    idx = 1'b1;
    tick(2);
    err_clr = 1'b1;
    tick(1);
    err_clr = 1'b0;
    chk("R12", "set wins over same-cycle clear", 32'(err), 1);
    idx = 1'b0; tick(4);
    t_clear();
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(3);
    t_reset();
    rst = 1'b0;
    tick(1);
    t_latency();
    t_up();
    t_down();
    t_illegal();
    t_wrap();
    t_enable();
    t_idx_off();
    t_idx_good();
    t_wrap_noidx();
    t_clear();
    t_idx_bad();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule